// File: doc/BRIEF.md
# Floating-Point Range Fixup Stage

This stage takes an arithmetic result that has already been normalized but not yet fitted to the destination. The result arrives as a sign, an unbounded biased exponent, a 64-bit significand with its integer bit at the top, and a guard bit and a sticky bit. The stage rounds the significand to a chosen precision and detects exponents the 15-bit field cannot hold. It then delivers a 1-15-64 extended result: sign, biased exponent, and a significand with an explicit integer bit.

Out-of-range results are handled according to two mask bits. If the event is masked, the stage substitutes a saturated value (infinity or the largest finite magnitude) or a denormal. If it is unmasked, the stage keeps the precision-rounded significand and moves the exponent back into range by a fixed bias adjustment. It also raises a request for an exception handler. The result and all flags are registered and appear one cycle after the input strobe.

Top module: `fp_range_fixup`

## Requirements
- R1: Every output is registered; `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and `exc_req`, `flag_ovf`, `flag_unf` and `flag_prec` are low whenever `out_valid` is low.
- R2: The significand is rounded to 24 bits when `pc`=00, to 53 bits when `pc`=10, and to 64 bits when `pc` is 11 or 01. The bits below the kept width are zero.
- R3: Rounding modes are `rmode` 00 nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. If rounding carries out of the integer bit, the significand becomes 8000_0000_0000_0000 and the exponent goes up by one.
- R4: `flag_prec` is set whenever rounding discards nonzero bits.
- R5: A masked overflow in mode 11 delivers the largest finite value with the result's sign: exponent 7FFE and the top p significand bits set, where p is the selected precision.
- R6: A masked overflow in mode 00 delivers infinity (exponent 7FFF, significand 8000_0000_0000_0000). In mode 10 it delivers +infinity for positive results and the negative largest finite value for negative results. Mode 01 mirrors mode 10.
- R7: Overflow is judged after rounding: a rounded biased exponent of 32767 or more is an overflow, and it raises `flag_ovf` and `flag_prec`.
- R8: An unmasked overflow delivers the rounded significand with the exponent reduced by 24576. It sets `flag_ovf`, `flag_prec` and `exc_req`.
- R9: A result is tiny when its input exponent is 0 or below. An unmasked tiny result delivers the significand rounded to the selected precision, with the exponent raised by 24576 after any rounding carry. It sets `flag_unf` and `exc_req`, and sets `flag_prec` only if the result is inexact.
- R10: A masked tiny result is shifted right by 1 minus its exponent, with the shifted-out bits kept as sticky, rounded per mode and precision, and delivered with exponent 0. `flag_unf` is set only if the result is inexact.
- R11: If rounding a denormal carries into the integer bit, the delivered value is the minimum normal: exponent 1, significand 8000_0000_0000_0000.
- R12: An all-zero significand with zero guard and sticky bits delivers a signed zero (exponent 0, significand 0) and raises no flag.
- R13: `exc_req` is raised only for an overflow while `ovf_mask` is low or a tiny result while `unf_mask` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input strobe |
| in_sign | input | 1 | Result sign |
| in_exp | input | EW (18) | Unbounded biased exponent, signed |
| in_sig | input | 64 | Normalized significand, integer bit at bit 63 |
| in_grd | input | 1 | Guard bit below the significand |
| in_stk | input | 1 | Sticky bit below the guard bit |
| rmode | input | 2 | Rounding mode |
| pc | input | 2 | Precision control |
| ovf_mask | input | 1 | Overflow masked when high |
| unf_mask | input | 1 | Underflow masked when high |
| out_valid | output | 1 | Result strobe |
| out_sign | output | 1 | Result sign |
| out_exp | output | 15 | Biased exponent |
| out_sig | output | 64 | Significand with explicit integer bit |
| flag_ovf | output | 1 | Overflow flag |
| flag_unf | output | 1 | Underflow flag |
| flag_prec | output | 1 | Precision (inexact) flag |
| exc_req | output | 1 | Handler request pulse |

## Verification
Two functions often coincide in one cycle: the precision flag together with the overflow or underflow flag, and the handler request together with a bias-wrapped exponent. The bench provokes these cases on purpose. It sends an unmasked tiny result whose discarded bits are nonzero, and an overflow that only appears after a rounding carry. It checks that each event raises its own flag, that the inexact flag is raised as well, and that the delivered exponent is the wrapped value. It also sends the exact counterparts, a masked tiny result that is exact and an unmasked one that is exact, to confirm that in those cases the flags stay apart.

// File: rtl/fp_range_fixup.sv
module fp_range_fixup #(
  parameter int EW       = 18,
  parameter int BIAS_ADJ = 24576,
  parameter int EMAX     = 32767
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sign,
  input  logic signed [EW-1:0] in_exp,
  input  logic [63:0]          in_sig,
  input  logic                 in_grd,
  input  logic                 in_stk,
  input  logic [1:0]           rmode,
  input  logic [1:0]           pc,
  input  logic                 ovf_mask,
  input  logic                 unf_mask,
  output logic                 out_valid,
  output logic                 out_sign,
  output logic [14:0]          out_exp,
  output logic [63:0]          out_sig,
  output logic                 flag_ovf,
  output logic                 flag_unf,
  output logic                 flag_prec,
  output logic                 exc_req
);
  localparam int VW = 66;
  localparam logic [VW-1:0] ONES = {VW{1'b1}};

  logic [VW-1:0] v, vd;
  logic signed [EW:0] dsh, e_r;
  logic [6:0] dd, k;
  logic zero, tiny, den, rbit, rest, lsb, inexact, inc, carry, ovf, to_inf;
  logic [63:0] keep;
  logic [64:0] sum;

  assign v    = {in_sig, in_grd, in_stk};
  assign zero = ~|v;
  assign tiny = in_exp <= 0;
  assign den  = tiny & unf_mask;
  assign dsh  = (EW+1)'(1) - (EW+1)'(in_exp);
  assign dd   = (dsh > 66) ? 7'd66 : dsh[6:0];
  assign vd   = den ? ((v >> dd) | {{(VW-1){1'b0}}, |(v & ~(ONES << dd))}) : v;

  always_comb
    case (pc)
      2'b00:   k = 7'd40;
      2'b10:   k = 7'd11;
      default: k = 7'd0;
    endcase

  assign keep    = {64{1'b1}} << k;
  assign rbit    = vd[7'(k + 7'd1)];
  assign rest    = |(vd & ~(ONES << (k + 7'd1)));
  assign lsb     = vd[7'(k + 7'd2)];
  assign inexact = rbit | rest;

  always_comb
    case (rmode)
      2'b00:   inc = rbit & (rest | lsb);
      2'b01:   inc = inexact & in_sign;
      2'b10:   inc = inexact & ~in_sign;
      default: inc = 1'b0;
    endcase

  assign sum    = {1'b0, vd[VW-1:2] & keep} + (65'(inc) << k);
  assign carry  = sum[64];
  assign e_r    = (EW+1)'(in_exp) + (EW+1)'(carry);
  assign ovf    = ~zero & ~tiny & (e_r >= (EW+1)'(EMAX));
  assign to_inf = (rmode == 2'b00) | (rmode == 2'b10 & ~in_sign) | (rmode == 2'b01 & in_sign);

  logic [14:0] n_exp;
  logic [63:0] n_sig;
  logic n_o, n_u, n_p, n_r;

  always_comb begin
    n_exp = e_r[14:0];
    n_sig = carry ? {1'b1, 63'b0} : sum[63:0];
    n_o = 1'b0; n_u = 1'b0; n_p = inexact; n_r = 1'b0;
    if (zero) begin
      n_exp = '0; n_sig = '0; n_p = 1'b0;
    end else if (ovf) begin
      n_o = 1'b1; n_p = 1'b1;
      if (ovf_mask) begin
        n_exp = to_inf ? 15'h7FFF : 15'h7FFE;
        n_sig = to_inf ? {1'b1, 63'b0} : keep;
      end else begin
        n_exp = 15'(e_r - (EW+1)'(BIAS_ADJ));
        n_r   = 1'b1;
      end
    end else if (tiny) begin
      if (unf_mask) begin
        n_exp = {14'b0, sum[63]};
        n_u   = inexact;
      end else begin
        n_exp = 15'(e_r + (EW+1)'(BIAS_ADJ));
        n_u   = 1'b1;
        n_r   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0; out_sign <= 1'b0; out_exp <= '0; out_sig <= '0;
      flag_ovf <= 1'b0; flag_unf <= 1'b0; flag_prec <= 1'b0; exc_req <= 1'b0;
    end else begin
      out_valid <= in_valid;
      flag_ovf  <= in_valid & n_o;
      flag_unf  <= in_valid & n_u;
      flag_prec <= in_valid & n_p;
      exc_req   <= in_valid & n_r;
      if (in_valid) begin
        out_sign <= in_sign;
        out_exp  <= n_exp;
        out_sig  <= n_sig;
      end
    end
endmodule

// File: rtl/fp_range_fixup_chk.sv
module fp_range_fixup_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic ovf_mask,
  input logic unf_mask,
  input logic out_valid,
  input logic [14:0] out_exp,
  input logic flag_ovf,
  input logic flag_unf,
  input logic flag_prec,
  input logic exc_req
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !exc_req && !flag_ovf && !flag_unf && !flag_prec);
  assert_ovf_prec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ovf |-> flag_prec);
  assert_events_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_ovf && flag_unf));
  assert_masked_unf_inexact_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_unf && !exc_req) |-> flag_prec);
  assert_masked_unf_exp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_unf && !exc_req) |-> (out_exp <= 15'd1));
  assert_req_unmasked_R13: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> ((flag_ovf && $past(!ovf_mask)) || (flag_unf && $past(!unf_mask))));
endmodule

bind fp_range_fixup fp_range_fixup_chk chk (.*);

// File: tb/fp_range_fixup_test.sv
module fp_range_fixup_test;
  typedef struct packed {
    logic sgn; logic [14:0] ex; logic [63:0] sg; logic o, u, p, r;
  } res_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sign = 1'b0, in_grd = 1'b0, in_stk = 1'b0;
  logic signed [17:0] in_exp = '0;
  logic [63:0] in_sig = '0;
  logic [1:0] rmode = '0, pc = '0;
  logic ovf_mask = 1'b0, unf_mask = 1'b0;
  logic out_valid, out_sign, flag_ovf, flag_unf, flag_prec, exc_req;
  logic [14:0] out_exp;
  logic [63:0] out_sig;

  int total = 0, bad = 0;
  res_t exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  fp_range_fixup uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_sig(in_sig), .in_grd(in_grd), .in_stk(in_stk), .rmode(rmode),
    .pc(pc), .ovf_mask(ovf_mask), .unf_mask(unf_mask), .out_valid(out_valid),
    .out_sign(out_sign), .out_exp(out_exp), .out_sig(out_sig), .flag_ovf(flag_ovf),
    .flag_unf(flag_unf), .flag_prec(flag_prec), .exc_req(exc_req));

  always #10 clk = ~clk;

  task automatic send(input logic s, input int e, input logic [63:0] sg, input logic g,
                      input logic st, input logic [1:0] rm, input logic [1:0] p,
                      input logic om, input logic um, input res_t x, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_sign = s; in_exp = 18'(e); in_sig = sg; in_grd = g; in_stk = st;
    rmode = rm; pc = p; ovf_mask = om; unf_mask = um;
    exp_q.push_back(x); tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      res_t a, x;
      string t;
      a = '{out_sign, out_exp, out_sig, flag_ovf, flag_unf, flag_prec, exc_req};
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R1 unexpected result: actual=%h expected=none", a);
      end else begin
        x = exp_q.pop_front(); t = tag_q.pop_front();
        if (a !== x) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", t, a, x);
        end
      end
    end
  end

  task automatic check_idle(input string tag);
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || exc_req !== 1'b0 || flag_prec !== 1'b0) begin
      bad++;
      $display("FAIL %s: actual=%b%b%b expected=000", tag, out_valid, exc_req, flag_prec);
    end
  endtask

  localparam logic [63:0] ONE = 64'h8000_0000_0000_0000;

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if ({out_valid, out_exp, out_sig, flag_ovf, flag_unf, flag_prec, exc_req} !== '0) begin
      bad++;
      $display("FAIL R1 reset: actual=%b/%h/%h expected=0", out_valid, out_exp, out_sig);
    end
    rst_n = 1'b1;
    // R12 zero first, then normal cases (R2, R3, R4)
    send(1, -5, 64'h0, 0, 0, 2'b00, 2'b11, 0, 0, '{1, 15'h0, 64'h0, 0, 0, 0, 0}, "R12 signed zero");
    send(0, 16383, ONE, 0, 0, 2'b00, 2'b11, 1, 1, '{0, 15'h3FFF, ONE, 0, 0, 0, 0}, "R2 exact");
    send(0, 16383, 64'h8000_0080_0000_0000, 0, 0, 2'b00, 2'b00, 1, 1,
         '{0, 15'h3FFF, ONE, 0, 0, 1, 0}, "R3 tie to even stays");
    send(0, 16383, 64'h8000_0180_0000_0000, 0, 0, 2'b00, 2'b00, 1, 1,
         '{0, 15'h3FFF, 64'h8000_0200_0000_0000, 0, 0, 1, 0}, "R3 tie to even bumps R4");
    send(0, 100, 64'hFFFF_FF00_0000_0001, 0, 0, 2'b10, 2'b00, 1, 1,
         '{0, 15'h0065, ONE, 0, 0, 1, 0}, "R3 carry to exponent");
    send(0, 16383, 64'h8000_0000_0000_0001, 0, 0, 2'b00, 2'b01, 1, 1,
         '{0, 15'h3FFF, 64'h8000_0000_0000_0001, 0, 0, 0, 0}, "R2 reserved pc is 64 bits");
    // masked overflow responses
    send(1, 32767, ONE, 0, 0, 2'b11, 2'b11, 1, 1,
         '{1, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 1, 0}, "R5 chop gives max finite");
    send(0, 40000, ONE, 0, 0, 2'b00, 2'b11, 1, 1, '{0, 15'h7FFF, ONE, 1, 0, 1, 0}, "R6 nearest gives inf");
    send(1, 32767, ONE, 0, 0, 2'b10, 2'b00, 1, 1,
         '{1, 15'h7FFE, 64'hFFFF_FF00_0000_0000, 1, 0, 1, 0}, "R6 up negative max finite");
    send(1, 32767, ONE, 0, 0, 2'b01, 2'b11, 1, 1, '{1, 15'h7FFF, ONE, 1, 0, 1, 0}, "R6 down negative inf");
    send(0, 32767, ONE, 0, 0, 2'b01, 2'b10, 1, 1,
         '{0, 15'h7FFE, 64'hFFFF_FFFF_FFFF_F800, 1, 0, 1, 0}, "R6 down positive max finite");
    send(0, 32766, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 2'b00, 2'b11, 1, 1,
         '{0, 15'h7FFF, ONE, 1, 0, 1, 0}, "R7 overflow after rounding");
    // unmasked responses
    send(0, 32772, ONE, 0, 0, 2'b00, 2'b11, 0, 1, '{0, 15'h2004, ONE, 1, 0, 1, 1}, "R8 unmasked overflow");
    send(1, -10, 64'hC000_0000_0000_0000, 0, 0, 2'b00, 2'b11, 1, 0,
         '{1, 15'h5FF6, 64'hC000_0000_0000_0000, 0, 1, 0, 1}, "R9 unmasked underflow exact");
    send(0, -3, 64'h8000_0080_0000_0001, 0, 0, 2'b00, 2'b00, 1, 0,
         '{0, 15'h5FFD, 64'h8000_0100_0000_0000, 0, 1, 1, 1}, "R9 unmasked underflow rounded");
    // masked underflow
    send(0, -1, 64'hC000_0000_0000_0000, 0, 0, 2'b00, 2'b11, 1, 1,
         '{0, 15'h0, 64'h3000_0000_0000_0000, 0, 0, 0, 0}, "R10 tiny exact no flag");
    send(0, -1, 64'hC000_0000_0000_0001, 0, 0, 2'b00, 2'b11, 1, 1,
         '{0, 15'h0, 64'h3000_0000_0000_0000, 0, 1, 1, 0}, "R10 tiny inexact");
    send(0, -200, ONE, 0, 0, 2'b11, 2'b11, 1, 1, '{0, 15'h0, 64'h0, 0, 1, 1, 0}, "R10 deep chop to zero");
    send(0, -200, ONE, 0, 0, 2'b10, 2'b00, 1, 1,
         '{0, 15'h0, 64'h0000_0100_0000_0000, 0, 1, 1, 0}, "R10 deep up at 24 bits");
    send(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 2'b10, 2'b11, 1, 1,
         '{0, 15'h1, ONE, 0, 1, 1, 0}, "R11 denormal rounds to min normal");
    // R13 masked events raise no request, even with the other mask low
    send(0, 32767, ONE, 0, 0, 2'b00, 2'b11, 1, 0, '{0, 15'h7FFF, ONE, 1, 0, 1, 0}, "R13 masked ovf no req");
    @(negedge clk);
    in_valid = 1'b0;
    check_idle("R1 idle after burst");
    check_idle("R1 idle second cycle");
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R1 missing results: actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule